// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Quad-Data-Rate SRAM Port Model

This block models the memory-side port logic of a quad-data-rate static RAM. It has an independent read port and write port that share one address bus. Each port moves a burst of two 18-bit words. The block runs on a single double-rate clock. A phase input tells the block whether each rising edge stands for the rising edge of the K clock or for the rising edge of its complement. The address selects a two-word line, and the position of a word inside the burst gives the low word bit.

A read is requested on a K-rise edge. Its two words leave the block one K cycle later, one word per edge, and a valid flag marks them. A write also starts on a K-rise edge, where the first word and its byte-enable pair are taken. The address, the second word and the second byte-enable pair follow on the next K#-rise edge. The write is held in a staging register and reaches the array one cycle later than a conventional device of this kind would commit it. Reads issued in the write's own cycle or in the next cycle therefore return the old line.

Top module: `qdr_b2_port`

## Requirements
- R1: The `k_rise` input is 1 on edges that stand for K-rise and 0 on edges that stand for K#-rise. The environment alternates it starting with 1, and the block samples its command selects only on edges where `k_rise` is 1.
- R2: A low `rd_n` on a K#-rise edge (`k_rise` 0) is ignored: no read burst follows.
- R3: A read issued on the K-rise edge of cycle t puts line word 0 on `rdata`, with `rvalid` high, at the K-rise edge of cycle t+1. It puts word 1 there at the K#-rise edge that follows.
- R4: A write issued with `wr_n` low on a K-rise edge takes `wdata` and `bw_n` there as word 0 and its enables. It takes `addr`, `wdata` and `bw_n` on the next K#-rise edge as the line address, word 1 and word 1's enables.
- R5: `bw_n` is active low. Bit 0 enables data bits 8:0 and bit 1 enables bits 17:9. A lane whose bit is 1 keeps its old contents. Each word of a burst uses its own pair.
- R6: Burst word 0 goes to word 0 of the addressed line and word 1 goes to word 1. A read returns word 0 first.
- R7: A write issued in cycle t is seen by reads issued in cycle t+2 or later. Reads issued in cycle t or t+1 return the contents from before the write.
- R8: Reads issued in consecutive cycles give an unbroken stream of words with `rvalid` high throughout.
- R9: On an edge with no burst word to deliver, `rvalid` is 0 and `rdata` keeps its previous value.
- R10: Reset (`rst_n` low) clears `rvalid` and `rdata` to 0 and discards any read or write in flight. The array itself is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is one K or K# edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_rise | input | 1 | 1 = this edge is K-rise, 0 = K#-rise |
| rd_n | input | 1 | Active-low read select, sampled on K-rise |
| wr_n | input | 1 | Active-low write select, sampled on K-rise |
| addr | input | ADDR_W | Read line address on K-rise; write line address on K#-rise |
| wdata | input | 18 | Write data: word 0 on K-rise, word 1 on K#-rise |
| bw_n | input | 2 | Active-low lane enables for the word on wdata |
| rdata | output | 18 | Read burst word |
| rvalid | output | 1 | High while rdata carries a burst word |

## Verification
A read and a write can be issued in the same K cycle. The read can target the line being written or a line written one or two cycles before. The bench issues such pairs at distances 0, 1 and 2 from a stimulus table. It predicts the returned words from a reference array in which a write lands only after the snapshot taken for the read of the following cycle. Every returned word is then compared, including the masked lanes, which must keep their old values.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
    localparam int DATA_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    // Merge new data into old, lane by lane, where the active-low enable is 0.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [LANES-1:0]  en_n
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int b = 0; b < LANES; b++) begin
            if (!en_n[b]) r[b*LANE_W +: LANE_W] = new_w[b*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/qdr_b2_store.sv
module qdr_b2_store
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wd0,
    input  logic [DATA_W-1:0] wd1,
    input  logic [LANES-1:0]  wm0_n,
    input  logic [LANES-1:0]  wm1_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1
);
    localparam int LINES = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_lo [LINES];
    logic [DATA_W-1:0] mem_hi [LINES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_lo[waddr] <= lane_merge(mem_lo[waddr], wd0, wm0_n);
            mem_hi[waddr] <= lane_merge(mem_hi[waddr], wd1, wm1_n);
        end
    end

    assign rd0 = mem_lo[raddr];
    assign rd1 = mem_hi[raddr];
endmodule

// File: rtl/qdr_b2_wr_ctrl.sv
module qdr_b2_wr_ctrl
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_rise,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  bw_n,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wd0,
    output logic [DATA_W-1:0] wd1,
    output logic [LANES-1:0]  wm0_n,
    output logic [LANES-1:0]  wm1_n
);
    typedef struct packed {
        logic              arm;   // first half of a write taken
        logic [DATA_W-1:0] w0;
        logic [LANES-1:0]  m0;
        logic              sv;    // staged write waiting to commit
        logic [ADDR_W-1:0] sa;
        logic [DATA_W-1:0] s0;
        logic [LANES-1:0]  sm0;
        logic [DATA_W-1:0] s1;
        logic [LANES-1:0]  sm1;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (k_rise) begin
            st_d.arm = !wr_n;
            if (!wr_n) begin
                st_d.w0 = wdata;
                st_d.m0 = bw_n;
            end
        end else begin
            // staged entry commits on this edge; refill from the armed half
            st_d.sv  = st_q.arm;
            st_d.arm = 1'b0;
            if (st_q.arm) begin
                st_d.sa  = addr;
                st_d.s0  = st_q.w0;
                st_d.sm0 = st_q.m0;
                st_d.s1  = wdata;
                st_d.sm1 = bw_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we    = st_q.sv && !k_rise;
    assign waddr = st_q.sa;
    assign wd0   = st_q.s0;
    assign wd1   = st_q.s1;
    assign wm0_n = st_q.sm0;
    assign wm1_n = st_q.sm1;
endmodule

// File: rtl/qdr_b2_rd_ctrl.sv
module qdr_b2_rd_ctrl
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_rise,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] snap0,
    input  logic [DATA_W-1:0] snap1,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic              pv;    // line snapshot waiting for output
        logic [DATA_W-1:0] p0;
        logic [DATA_W-1:0] p1;
        logic [DATA_W-1:0] h1;    // word 1 held for the K# edge
        logic              sec;
        logic              rv;
        logic [DATA_W-1:0] rd;
    } rst_t;

    rst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (k_rise) begin
            st_d.rv  = st_q.pv;
            st_d.sec = st_q.pv;
            if (st_q.pv) begin
                st_d.rd = st_q.p0;
                st_d.h1 = st_q.p1;
            end
            st_d.pv = !rd_n;
            if (!rd_n) begin
                st_d.p0 = snap0;
                st_d.p1 = snap1;
            end
        end else begin
            st_d.rv  = st_q.sec;
            st_d.sec = 1'b0;
            if (st_q.sec) st_d.rd = st_q.h1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rd;
    assign rvalid = st_q.rv;
endmodule

// File: rtl/qdr_b2_port.sv
module qdr_b2_port
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_rise,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  bw_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wd0, mem_wd1, snap0, snap1;
    logic [LANES-1:0]  mem_wm0, mem_wm1;

    qdr_b2_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .bw_n(bw_n),
        .we(mem_we), .waddr(mem_waddr), .wd0(mem_wd0), .wd1(mem_wd1),
        .wm0_n(mem_wm0), .wm1_n(mem_wm1)
    );

    qdr_b2_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr),
        .wd0(mem_wd0), .wd1(mem_wd1), .wm0_n(mem_wm0), .wm1_n(mem_wm1),
        .raddr(addr), .rd0(snap0), .rd1(snap1)
    );

    qdr_b2_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .rd_n(rd_n),
        .snap0(snap0), .snap1(snap1), .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: rtl/qdr_b2_port_chk.sv
module qdr_b2_port_chk
    import qdr_b2_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              k_rise,
    input logic              rd_n,
    input logic              wr_n,
    input logic              mem_we,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata
);
    // R3: both burst words follow a read one K cycle later
    a_r3_read_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (k_rise && !rd_n) |-> ##3 rvalid ##1 rvalid);

    // R2: a burst only starts after a read taken on a K-rise edge
    a_r2_burst_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> $past(k_rise && !rd_n, 3));

    // R7: array update on a K# edge, one full cycle after the write was issued
    a_r7_commit_delay: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!k_rise && $past(k_rise && !wr_n, 3)));

    // R9: output held when no word is delivered
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> $stable(rdata));
endmodule

bind qdr_b2_port qdr_b2_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .rd_n(rd_n), .wr_n(wr_n),
    .mem_we(mem_we), .rvalid(rvalid), .rdata(rdata)
);

// File: tb/qdr_b2_port_tb.sv
module qdr_b2_port_tb;
    localparam int AW = 4;
    localparam int NL = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_rise = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [17:0]   wdata = '0;
    logic [1:0]    bw_n = 2'b11;
    logic [17:0]   rdata;
    logic          rvalid;

    qdr_b2_port #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rvalid(rvalid)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    logic [17:0] ref0 [NL];
    logic [17:0] ref1 [NL];
    bit          pw_v = 1'b0;
    logic [AW-1:0] pw_a;
    logic [17:0] pw_0, pw_1;
    logic [1:0]  pw_m0, pw_m1;
    bit          prv_rd = 1'b0;
    logic [17:0] prv0, prv1;
    logic [17:0] last = '0;
    string       prv_tag = "R9";

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] ra;
        logic          wr;
        logic [AW-1:0] wa;
        logic [17:0]   w0;
        logic [1:0]    m0;
        logic [17:0]   w1;
        logic [1:0]    m1;
    } vec_t;

    // read/write pairs at distances 0, 1, 2 (R7), masked lanes (R5)
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd0, 1'b1, 4'd3, 18'h12345, 2'b00, 18'h0ABCD, 2'b00},
        '{1'b1, 4'd3, 1'b0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11},
        '{1'b1, 4'd3, 1'b0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11},
        '{1'b1, 4'd5, 1'b1, 4'd5, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01},
        '{1'b1, 4'd5, 1'b1, 4'd7, 18'h2AAAA, 2'b11, 18'h15555, 2'b11},
        '{1'b1, 4'd5, 1'b1, 4'd8, 18'h11111, 2'b00, 18'h22222, 2'b00},
        '{1'b1, 4'd7, 1'b1, 4'd8, 18'h33333, 2'b01, 18'h04444, 2'b10},
        '{1'b1, 4'd8, 1'b0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11},
        '{1'b1, 4'd8, 1'b1, 4'd0, 18'h0F0F0, 2'b00, 18'h30303, 2'b00},
        '{1'b1, 4'd0, 1'b0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11}
    };

    function automatic logic [17:0] merge(input logic [17:0] o, input logic [17:0] n, input logic [1:0] m);
        logic [17:0] r;
        r = o;
        if (!m[0]) r[8:0]  = n[8:0];
        if (!m[1]) r[17:9] = n[17:9];
        return r;
    endfunction

    task automatic chk(input string tag, input logic v, input logic [17:0] d);
        checks++;
        if (rvalid !== v || rdata !== d) begin
            fails++;
            $display("FAIL %s: got rvalid=%0b rdata=%05h, expected rvalid=%0b rdata=%05h",
                     tag, rvalid, rdata, v, d);
        end
    endtask

    // one K cycle, entered and left at a falling clock edge
    task automatic kcyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                        input logic [17:0] w0, input logic [1:0] m0,
                        input logic [17:0] w1, input logic [1:0] m1,
                        input bit rdk, input string tag);
        logic [17:0] s0, s1;
        s0 = ref0[ra];
        s1 = ref1[ra];
        if (pw_v) begin
            ref0[pw_a] = merge(ref0[pw_a], pw_0, pw_m0);
            ref1[pw_a] = merge(ref1[pw_a], pw_1, pw_m1);
        end
        pw_v = wr; pw_a = wa; pw_0 = w0; pw_1 = w1; pw_m0 = m0; pw_m1 = m1;
        k_rise = 1'b1; rd_n = !rd; wr_n = !wr; addr = ra; wdata = w0; bw_n = m0;
        @(posedge clk); @(negedge clk);
        if (prv_rd) begin chk(prv_tag, 1'b1, prv0); last = prv0; end
        else chk(prv_tag, 1'b0, last);
        k_rise = 1'b0; rd_n = !rdk; wr_n = 1'b1; addr = wa; wdata = w1; bw_n = m1;
        @(posedge clk); @(negedge clk);
        if (prv_rd) begin chk(prv_tag, 1'b1, prv1); last = prv1; end
        else chk(prv_tag, 1'b0, last);
        prv_rd = rd; prv0 = s0; prv1 = s1; prv_tag = tag;
    endtask

    task automatic idle(input string tag);
        kcyc(1'b0, '0, 1'b0, '0, '0, 2'b11, '0, 2'b11, 1'b0, tag);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset state", 1'b0, 18'h0);
        rst_n = 1'b1;
        k_rise = 1'b1;

        // R4/R6: preload every line with distinct words
        for (int l = 0; l < NL; l++)
            kcyc(1'b0, '0, 1'b1, AW'(l), {4'(l), 14'h1234}, 2'b00, {~4'(l), 14'h2345}, 2'b00, 1'b0, "R4");
        idle("R9");
        // R8: back-to-back read stream over all lines, R6 word order
        for (int l = 0; l < NL; l++)
            kcyc(1'b1, AW'(l), 1'b0, '0, '0, 2'b11, '0, 2'b11, 1'b0, "R8");
        idle("R6");

        // R7 table: read-after-write distances and masked writes
        for (int i = 0; i < NV; i++)
            kcyc(VEC[i].rd, VEC[i].ra, VEC[i].wr, VEC[i].wa, VEC[i].w0, VEC[i].m0,
                 VEC[i].w1, VEC[i].m1, 1'b0, "R7");
        idle("R9");
        idle("R9");

        // R5: only the upper lane of word 0 and the lower lane of word 1
        kcyc(1'b0, '0, 1'b1, 4'd11, 18'h3FE00, 2'b01, 18'h001FF, 2'b10, 1'b0, "R5");
        idle("R5");
        kcyc(1'b1, 4'd11, 1'b0, '0, '0, 2'b11, '0, 2'b11, 1'b0, "R5");
        // R1: a read on a K-rise edge, lines 2 and 13 back to back
        kcyc(1'b1, 4'd2, 1'b0, '0, '0, 2'b11, '0, 2'b11, 1'b0, "R1");
        kcyc(1'b1, 4'd13, 1'b0, '0, '0, 2'b11, '0, 2'b11, 1'b0, "R1");
        idle("R9");
        // R2: read select on a K# edge only
        kcyc(1'b0, 4'd4, 1'b0, 4'd4, '0, 2'b11, '0, 2'b11, 1'b1, "R2");
        idle("R2");
        idle("R9");

        // R10: reset between write capture and commit, plus a read in flight
        kcyc(1'b1, 4'd6, 1'b1, 4'd9, 18'h1DEAD, 2'b00, 18'h0BEEF, 2'b00, 1'b0, "R10");
        rst_n = 1'b0;
        pw_v = 1'b0; prv_rd = 1'b0; last = '0;
        @(posedge clk); @(negedge clk);
        chk("R10 reset clears output", 1'b0, 18'h0);
        @(posedge clk); @(negedge clk);
        chk("R10 reset held", 1'b0, 18'h0);
        k_rise = 1'b1;
        rst_n = 1'b1;
        idle("R10");
        kcyc(1'b1, 4'd9, 1'b0, '0, '0, 2'b11, '0, 2'b11, 1'b0, "R10");
        idle("R10");
        idle("R9");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            summary();
            $finish;
        end
    end
endmodule